// File: doc/BRIEF.md
# Four-Way Mesh Processing Array

This block is a rectangular array of small processing tiles wired as a four-way mesh. Each tile has four inputs, one for each compass direction, and one registered output. That output goes to the facing input of every neighbour: a tile's eastern neighbour sees it on its west input, and the tile below sees it on its north input. Rows are numbered downward from the top and columns rightward from the left.

A ring of IO cells surrounds the array. There is one cell for each boundary tile edge on every side, and none at the four corners. Each IO cell feeds an external input bus into the facing input of its boundary tile, and presents that tile's output on an external output bus.

Every tile holds a configuration word. The word chooses two operand sources and one arithmetic or logic operation. A single configuration port writes one tile at a time, chosen by row and column address, so software can set up the array tile by tile. Because every tile output is a register, data moves one tile per clock cycle when a chain of tiles is set to forward it.

Top module: `cgra_mesh_top`

## Requirements
- R1: While rstN is low, every tile output and every tile configuration word is zero, so all of ioOut reads zero.
- R2: When cfgWe is high at a rising clock edge, only the tile at (cfgRow, cfgCol) loads cfgData. The word layout is: bits 8:6 are the operation, bits 5:3 are the source of operand A, and bits 2:0 are the source of operand B. All other tiles keep their configuration.
- R3: When cfgWe is low, no tile configuration changes, whatever cfgData, cfgRow and cfgCol carry.
- R4: The source codes for both operands are:
  - 0 selects the north input.
  - 1 selects the east input.
  - 2 selects the west input.
  - 3 selects the south input.
  - 4 selects the tile's own registered output.
  - 5, 6 and 7 select zero.
- R5: The operation codes are:
  - 0 passes A.
  - 1 computes A+B.
  - 2 computes A-B.
  - 3 computes A AND B.
  - 4 computes A OR B.
  - 5 computes A XOR B.
  - 6 computes A shifted left by the low log2(DATA_W) bits of B.
  - 7 computes the low DATA_W bits of A*B.
- R6: A tile's output register loads the result on every rising edge. A value forwarded through a chain of tiles therefore advances one tile per cycle.
- R7: Neighbour inputs are wired by direction. The north input comes from the tile above and the east input from the tile to the right. The west input comes from the tile to the left and the south input from the tile below.
- R8: The IO ring has 2*(CGRA_ROWS+CGRA_COLS) cells, each DATA_W bits wide in ioIn and ioOut. The cells are ordered as follows:
  - North cells come first, indexed by column.
  - South cells come next, indexed by column.
  - West cells follow, indexed by row.
  - East cells come last, indexed by row.
- R9: Each IO cell's ioIn drives the facing input of its boundary tile. Each IO cell's ioOut shows that tile's output. A corner tile appears on two cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all tile registers |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgRow | input | ROW_AW | Row address of the tile to configure |
| cfgCol | input | COL_AW | Column address of the tile to configure |
| cfgData | input | 9 | Configuration word {op, srcA, srcB} |
| ioIn | input | NIO*DATA_W | External input buses, one per IO cell |
| ioOut | output | NIO*DATA_W | External output buses, one per IO cell |

## Verification
Each of the four directions is tested on its own. The whole array is set to forward from one side, a single IO cell is driven, and the bench checks that the value appears at the near tile after one edge and at the far tile after two. This shows that each direction is wired to the correct neighbour and is not swapped. One tile is then fed two distinct operands, and every operation code is applied to them; the chosen values give each operation a different result. Further patterns cover the following:
- an accumulating tile that feeds back its own output;
- an unused source code;
- a rewrite of a single tile, with its neighbours checked to show they keep their configuration;
- data changes while the write strobe is low.

// File: rtl/cgra_mesh_pkg.sv
package cgra_mesh_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_SHL  = 3'd6,
    OP_MUL  = 3'd7
  } tileOp_e;

  localparam logic [2:0] SRC_NORTH = 3'd0;
  localparam logic [2:0] SRC_EAST  = 3'd1;
  localparam logic [2:0] SRC_WEST  = 3'd2;
  localparam logic [2:0] SRC_SOUTH = 3'd3;
  localparam logic [2:0] SRC_SELF  = 3'd4;

  typedef struct packed {
    tileOp_e    op;
    logic [2:0] srcA;
    logic [2:0] srcB;
  } tileCfg_t;

  localparam int CFG_W = $bits(tileCfg_t);

  // Strobes from the configuration control to the datapath
  typedef struct packed {
    logic     write;
    tileCfg_t word;
  } cfgStrobe_t;

endpackage

// File: rtl/cgra_cfg_ctrl.sv
module cgra_cfg_ctrl
  import cgra_mesh_pkg::*;
#(
  parameter int CGRA_ROWS = 2,
  parameter int CGRA_COLS = 2,
  parameter int ROW_AW    = 1,
  parameter int COL_AW    = 1,
  localparam int TILES    = CGRA_ROWS * CGRA_COLS
) (
  input  logic              cfgWe,
  input  logic [ROW_AW-1:0] cfgRow,
  input  logic [COL_AW-1:0] cfgCol,
  input  logic [CFG_W-1:0]  cfgData,
  output cfgStrobe_t        strobe,
  output logic [TILES-1:0]  tileSel
);

  assign strobe.write = cfgWe;
  assign strobe.word  = tileCfg_t'(cfgData);

  for (genvar r = 0; r < CGRA_ROWS; r++) begin : gRow
    for (genvar c = 0; c < CGRA_COLS; c++) begin : gCol
      assign tileSel[r*CGRA_COLS + c] = cfgWe
                                        && (cfgRow == ROW_AW'(r))
                                        && (cfgCol == COL_AW'(c));
    end
  end

endmodule

// File: rtl/cgra_tile.sv
module cgra_tile
  import cgra_mesh_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SH_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  tileCfg_t          cfgWord,
  input  logic [DATA_W-1:0] inNorth,
  input  logic [DATA_W-1:0] inEast,
  input  logic [DATA_W-1:0] inWest,
  input  logic [DATA_W-1:0] inSouth,
  output logic [DATA_W-1:0] tileOut,
  output tileCfg_t          cfgQ
);

  logic [DATA_W-1:0] opA, opB, result;

  function automatic logic [DATA_W-1:0] pickSrc(
    input logic [2:0]        sel,
    input logic [DATA_W-1:0] n, e, w, s, self
  );
    case (sel)
      SRC_NORTH: return n;
      SRC_EAST:  return e;
      SRC_WEST:  return w;
      SRC_SOUTH: return s;
      SRC_SELF:  return self;
      default:   return '0;
    endcase
  endfunction

  always_comb begin
    opA = pickSrc(cfgQ.srcA, inNorth, inEast, inWest, inSouth, tileOut);
    opB = pickSrc(cfgQ.srcB, inNorth, inEast, inWest, inSouth, tileOut);
    case (cfgQ.op)
      OP_PASS: result = opA;
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_AND:  result = opA & opB;
      OP_OR:   result = opA | opB;
      OP_XOR:  result = opA ^ opB;
      OP_SHL:  result = opA << opB[SH_W-1:0];
      OP_MUL:  result = opA * opB;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      tileOut <= '0;
    end else begin
      if (cfgWr) cfgQ <= cfgWord;
      tileOut <= result;
    end
  end

endmodule

// File: rtl/cgra_mesh_dp.sv
module cgra_mesh_dp
  import cgra_mesh_pkg::*;
#(
  parameter int CGRA_ROWS = 2,
  parameter int CGRA_COLS = 2,
  parameter int DATA_W    = 16,
  localparam int TILES    = CGRA_ROWS * CGRA_COLS,
  localparam int NIO      = 2 * (CGRA_ROWS + CGRA_COLS),
  localparam int SOUTH0   = CGRA_COLS,
  localparam int WEST0    = 2 * CGRA_COLS,
  localparam int EAST0    = 2 * CGRA_COLS + CGRA_ROWS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfgStrobe_t              strobe,
  input  logic [TILES-1:0]        tileSel,
  input  logic [NIO*DATA_W-1:0]   ioIn,
  output logic [NIO*DATA_W-1:0]   ioOut,
  output logic [TILES*DATA_W-1:0] tileOutFlat,
  output logic [TILES*CFG_W-1:0]  tileCfgFlat
);

  logic [DATA_W-1:0] outQ [CGRA_ROWS][CGRA_COLS];

  for (genvar r = 0; r < CGRA_ROWS; r++) begin : gRow
    for (genvar c = 0; c < CGRA_COLS; c++) begin : gCol
      localparam int T = r * CGRA_COLS + c;
      logic [DATA_W-1:0] nIn, eIn, wIn, sIn;
      tileCfg_t          cfgQ;

      if (r == 0) begin : gNio
        assign nIn = ioIn[c*DATA_W +: DATA_W];
      end else begin : gNt
        assign nIn = outQ[r-1][c];
      end
      if (r == CGRA_ROWS-1) begin : gSio
        assign sIn = ioIn[(SOUTH0+c)*DATA_W +: DATA_W];
      end else begin : gSt
        assign sIn = outQ[r+1][c];
      end
      if (c == 0) begin : gWio
        assign wIn = ioIn[(WEST0+r)*DATA_W +: DATA_W];
      end else begin : gWt
        assign wIn = outQ[r][c-1];
      end
      if (c == CGRA_COLS-1) begin : gEio
        assign eIn = ioIn[(EAST0+r)*DATA_W +: DATA_W];
      end else begin : gEt
        assign eIn = outQ[r][c+1];
      end

      cgra_tile #(.DATA_W(DATA_W)) uTile (
        .clk     (clk),
        .rstN    (rstN),
        .cfgWr   (strobe.write && tileSel[T]),
        .cfgWord (strobe.word),
        .inNorth (nIn),
        .inEast  (eIn),
        .inWest  (wIn),
        .inSouth (sIn),
        .tileOut (outQ[r][c]),
        .cfgQ    (cfgQ)
      );

      assign tileOutFlat[T*DATA_W +: DATA_W] = outQ[r][c];
      assign tileCfgFlat[T*CFG_W +: CFG_W]   = cfgQ;
    end
  end

  for (genvar c = 0; c < CGRA_COLS; c++) begin : gIoCol
    assign ioOut[c*DATA_W +: DATA_W]          = outQ[0][c];
    assign ioOut[(SOUTH0+c)*DATA_W +: DATA_W] = outQ[CGRA_ROWS-1][c];
  end
  for (genvar r = 0; r < CGRA_ROWS; r++) begin : gIoRow
    assign ioOut[(WEST0+r)*DATA_W +: DATA_W] = outQ[r][0];
    assign ioOut[(EAST0+r)*DATA_W +: DATA_W] = outQ[r][CGRA_COLS-1];
  end

endmodule

// File: rtl/cgra_mesh_top.sv
module cgra_mesh_top
  import cgra_mesh_pkg::*;
#(
  parameter int CGRA_ROWS = 2,
  parameter int CGRA_COLS = 2,
  parameter int DATA_W    = 16,
  localparam int ROW_AW   = (CGRA_ROWS > 1) ? $clog2(CGRA_ROWS) : 1,
  localparam int COL_AW   = (CGRA_COLS > 1) ? $clog2(CGRA_COLS) : 1,
  localparam int NIO      = 2 * (CGRA_ROWS + CGRA_COLS),
  localparam int TILES    = CGRA_ROWS * CGRA_COLS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [ROW_AW-1:0]     cfgRow,
  input  logic [COL_AW-1:0]     cfgCol,
  input  logic [CFG_W-1:0]      cfgData,
  input  logic [NIO*DATA_W-1:0] ioIn,
  output logic [NIO*DATA_W-1:0] ioOut
);

  cfgStrobe_t              strobe;
  logic [TILES-1:0]        tileSel;
  logic [TILES*DATA_W-1:0] tileOutFlat;
  logic [TILES*CFG_W-1:0]  tileCfgFlat;

  cgra_cfg_ctrl #(
    .CGRA_ROWS(CGRA_ROWS), .CGRA_COLS(CGRA_COLS),
    .ROW_AW(ROW_AW), .COL_AW(COL_AW)
  ) uCtrl (
    .cfgWe   (cfgWe),
    .cfgRow  (cfgRow),
    .cfgCol  (cfgCol),
    .cfgData (cfgData),
    .strobe  (strobe),
    .tileSel (tileSel)
  );

  cgra_mesh_dp #(
    .CGRA_ROWS(CGRA_ROWS), .CGRA_COLS(CGRA_COLS), .DATA_W(DATA_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .tileSel     (tileSel),
    .ioIn        (ioIn),
    .ioOut       (ioOut),
    .tileOutFlat (tileOutFlat),
    .tileCfgFlat (tileCfgFlat)
  );

endmodule

// File: rtl/cgra_mesh_chk.sv
module cgra_mesh_chk
  import cgra_mesh_pkg::*;
#(
  parameter int CGRA_ROWS = 2,
  parameter int CGRA_COLS = 2,
  parameter int DATA_W    = 16,
  parameter int ROW_AW    = 1,
  parameter int COL_AW    = 1,
  localparam int TILES    = CGRA_ROWS * CGRA_COLS
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cfgWe,
  input logic [ROW_AW-1:0]       cfgRow,
  input logic [COL_AW-1:0]       cfgCol,
  input logic [CFG_W-1:0]        cfgData,
  input logic [TILES*DATA_W-1:0] tileOutFlat,
  input logic [TILES*CFG_W-1:0]  tileCfgFlat
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3
  no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(tileCfgFlat));

  for (genvar r = 0; r < CGRA_ROWS; r++) begin : gRow
    for (genvar c = 0; c < CGRA_COLS; c++) begin : gCol
      localparam int T = r * CGRA_COLS + c;

      // R2
      cfg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        (cfgWe && cfgRow == ROW_AW'(r) && cfgCol == COL_AW'(c))
        |=> tileCfgFlat[T*CFG_W +: CFG_W] == $past(cfgData));

      if (r > 0) begin : gNorth
        // R6 R7
        hop_north_chk: assert property (@(posedge clk) disable iff (!rstN)
          (pastValid && $past(tileCfgFlat[T*CFG_W+6 +: 3] == 3'd0
                              && tileCfgFlat[T*CFG_W+3 +: 3] == SRC_NORTH))
          |-> tileOutFlat[T*DATA_W +: DATA_W]
              == $past(tileOutFlat[(T-CGRA_COLS)*DATA_W +: DATA_W]));
      end

      if (c < CGRA_COLS-1) begin : gEast
        // R6 R7
        hop_east_chk: assert property (@(posedge clk) disable iff (!rstN)
          (pastValid && $past(tileCfgFlat[T*CFG_W+6 +: 3] == 3'd0
                              && tileCfgFlat[T*CFG_W+3 +: 3] == SRC_EAST))
          |-> tileOutFlat[T*DATA_W +: DATA_W]
              == $past(tileOutFlat[(T+1)*DATA_W +: DATA_W]));
      end
    end
  end

endmodule

bind cgra_mesh_top cgra_mesh_chk #(
  .CGRA_ROWS(CGRA_ROWS), .CGRA_COLS(CGRA_COLS), .DATA_W(DATA_W),
  .ROW_AW(ROW_AW), .COL_AW(COL_AW)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWe       (cfgWe),
  .cfgRow      (cfgRow),
  .cfgCol      (cfgCol),
  .cfgData     (cfgData),
  .tileOutFlat (tileOutFlat),
  .tileCfgFlat (tileCfgFlat)
);

// File: tb/cgra_mesh_top_test.sv
`timescale 1ns/1ps
module cgra_mesh_top_test;

  localparam int DW  = 16;
  localparam int NIO = 8;
  // IO cell indices for a 2x2 interior
  localparam int N0 = 0, N1 = 1, S0 = 2, S1 = 3, W0 = 4, W1 = 5, E0 = 6, E1 = 7;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [0:0]       cfgRow = '0;
  logic [0:0]       cfgCol = '0;
  logic [8:0]       cfgData = '0;
  logic [NIO*DW-1:0] ioIn = '0;
  logic [NIO*DW-1:0] ioOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cgra_mesh_top #(.CGRA_ROWS(2), .CGRA_COLS(2), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRow(cfgRow), .cfgCol(cfgCol),
    .cfgData(cfgData), .ioIn(ioIn), .ioOut(ioOut)
  );

  function automatic logic [DW-1:0] outAt(int idx);
    return ioOut[idx*DW +: DW];
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIo(int idx, logic [DW-1:0] v);
    ioIn[idx*DW +: DW] = v;
  endtask

  task automatic writeCfg(int r, int c, logic [2:0] op, logic [2:0] a, logic [2:0] b);
    cfgRow  = 1'(r);
    cfgCol  = 1'(c);
    cfgData = {op, a, b};
    cfgWe   = 1'b1;
    step(1);
    cfgWe   = 1'b0;
  endtask

  task automatic cfgAllPass(logic [2:0] src);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 2; c++)
        writeCfg(r, c, 3'd0, src, 3'd0);
    ioIn = '0;
    step(3);
  endtask

  task automatic testReset();
    for (int i = 0; i < NIO; i++) check("R1 reset output", outAt(i), '0);
  endtask

  task automatic testNorth();
    cfgAllPass(3'd0);
    setIo(N0, 16'hA1A1);
    step(1);
    check("R9 north cell into tile(0,0)", outAt(N0), 16'hA1A1);
    check("R6 tile(1,0) one cycle behind", outAt(S0), 16'h0000);
    step(1);
    check("R7 north hop reaches tile(1,0)", outAt(S0), 16'hA1A1);
    check("R8 corner tile(1,0) also on west cell 1", outAt(W1), 16'hA1A1);
  endtask

  task automatic testEast();
    cfgAllPass(3'd1);
    setIo(E0, 16'hB2B2);
    step(1);
    check("R9 east cell into tile(0,1)", outAt(E0), 16'hB2B2);
    check("R6 tile(0,0) one cycle behind", outAt(W0), 16'h0000);
    step(1);
    check("R7 east hop reaches tile(0,0)", outAt(W0), 16'hB2B2);
  endtask

  task automatic testWest();
    cfgAllPass(3'd2);
    setIo(W1, 16'hC3C3);
    step(1);
    check("R9 west cell into tile(1,0)", outAt(W1), 16'hC3C3);
    check("R6 tile(1,1) one cycle behind", outAt(E1), 16'h0000);
    step(1);
    check("R7 west hop reaches tile(1,1)", outAt(E1), 16'hC3C3);
  endtask

  task automatic testSouth();
    cfgAllPass(3'd3);
    setIo(S1, 16'hD4D4);
    step(1);
    check("R9 south cell into tile(1,1)", outAt(S1), 16'hD4D4);
    check("R6 tile(0,1) one cycle behind", outAt(N1), 16'h0000);
    step(1);
    check("R7 south hop reaches tile(0,1)", outAt(N1), 16'hD4D4);
  endtask

  task automatic testSingleWrite();
    cfgAllPass(3'd0);
    setIo(N0, 16'h0010);
    setIo(N1, 16'h0021);
    step(3);
    writeCfg(0, 1, 3'd1, 3'd0, 3'd0);
    step(1);
    check("R2 addressed tile(0,1) adds", outAt(N1), 16'h0042);
    check("R2 tile(1,1) unchanged", outAt(S1), 16'h0021);
    check("R2 tile(0,0) unchanged", outAt(N0), 16'h0010);
    check("R2 tile(1,0) unchanged", outAt(S0), 16'h0010);
    step(1);
    check("R2 tile(1,1) forwards new value", outAt(S1), 16'h0042);
  endtask

  task automatic testOps();
    logic [DW-1:0] exp [8];
    exp[0] = 16'h00F3; exp[1] = 16'h00F8; exp[2] = 16'h00EE; exp[3] = 16'h0001;
    exp[4] = 16'h00F7; exp[5] = 16'h00F6; exp[6] = 16'h1E60; exp[7] = 16'h04BF;
    setIo(N0, 16'h00F3);
    setIo(W0, 16'h0005);
    for (int op = 0; op < 8; op++) begin
      writeCfg(0, 0, 3'(op), 3'd0, 3'd2);
      step(1);
      check($sformatf("R5 op %0d north-A west-B", op), outAt(N0), exp[op]);
    end
  endtask

  task automatic testFeedback();
    setIo(N0, 16'h0000);
    writeCfg(0, 0, 3'd0, 3'd0, 3'd0);
    step(1);
    check("R4 cleared before accumulate", outAt(N0), 16'h0000);
    writeCfg(0, 0, 3'd1, 3'd4, 3'd0);
    setIo(N0, 16'h0003);
    step(3);
    check("R4 own output accumulates", outAt(N0), 16'h0009);
  endtask

  task automatic testUnusedSrc();
    writeCfg(0, 0, 3'd0, 3'd5, 3'd0);
    step(1);
    check("R4 source code 5 gives zero", outAt(N0), 16'h0000);
  endtask

  task automatic testNoWrite();
    setIo(N0, 16'h0077);
    cfgRow = 1'b0;
    cfgCol = 1'b0;
    cfgData = {3'd0, 3'd0, 3'd0};
    cfgWe = 1'b0;
    step(2);
    check("R3 no strobe keeps config", outAt(N0), 16'h0000);
  endtask

  initial begin
    step(3);
    testReset();
    rstN = 1'b1;
    step(1);
    testReset();
    testNorth();
    testEast();
    testWest();
    testSouth();
    testSingleWrite();
    testOps();
    testFeedback();
    testUnusedSrc();
    testNoWrite();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule